// File: doc/BRIEF.md
# Floating-Point Exception Flag Accumulator

This block keeps the exception-recording part of a 32-bit floating-point status word. Every time the arithmetic pipeline retires an operation it presents a completion strobe together with five raw exception indications: inexact, underflow, overflow, divide-by-zero and invalid. The block reorders those indications into the bit order used by the trap-enable field. It then shifts them up into the sticky flag field and ORs them into the word. Flags only ever accumulate. Software is the only agent that can clear them, by loading a new word.

The word holds two fields that use the same bit ordering. The per-class trap enables sit at the bottom of the word and the sticky flags sit at the top. When an operation raises any exception whose enable bit is set, the block emits a registered one-cycle request for an assist trap. A software load replaces the whole word at once. When a load coincides with a completing operation, the load wins and that operation is discarded. The raw indications are only looked at in a cycle that carries the completion strobe, so nothing from one operation leaks into the next.

Top module: `fpx_flag_accum`

## Requirements
- R1: A synchronous active-high reset clears `status` to all zeros and holds `trap_req` low.
- R2: `op_exc` is ordered bit4 = inexact, bit3 = underflow, bit2 = overflow, bit1 = divide-by-zero, bit0 = invalid. The enable field `status[4:0]` and the flag field `status[31:27]` both use the order invalid (bit 4 / bit 31), divide-by-zero (3 / 30), overflow (2 / 29), underflow (1 / 28), inexact (0 / 27). A completed operation sets the flag bit of every class it raises.
- R3: Flags are sticky. An operation update ORs new flags in and never clears a flag that is already set.
- R4: An operation that completes with no exception leaves `status` unchanged and produces no trap request.
- R5: When a completing operation raises any class whose enable bit is set, `trap_req` is high for exactly the one cycle after the update edge. Otherwise it stays low.
- R6: A class that is raised while its enable bit is clear updates its flag but does not request a trap.
- R7: When `sw_we` is high, `status` is loaded with `sw_wdata` at the next edge. This has priority over an operation in the same cycle: that operation changes no flag and requests no trap.
- R8: While `op_done` is low, `op_exc` is ignored. `status` stays unchanged and no trap is requested.
- R9: A trap is requested even when the raised class's flag was already set by an earlier operation.
- R10: An operation update never changes the enable field or the bits between the two fields (`status[26:0]`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_done | input | 1 | Strobe marking a completed FP operation |
| op_exc | input | 5 | Raw exception indications of that operation (order in R2) |
| sw_we | input | 1 | Software load of the whole status word |
| sw_wdata | input | 32 | Word loaded when `sw_we` is high |
| status | output | 32 | Current status word |
| trap_req | output | 1 | One-cycle assist-trap request |

## Verification
A software load and a completing operation can arrive in the same cycle. The bench provokes this by holding `sw_we` and `op_done` high together while the raised exceptions would both set new flags and hit set enables. It judges the outcome on the next cycle: `status` must equal exactly the loaded word, and `trap_req` must stay low. Outside that collision, the bench sweeps every combination of raw exceptions against every enable pattern, each time from a freshly loaded word. It compares the flag field and the trap pulse against a model that reorders and shifts in arithmetic.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    // Number of exception classes recorded by the status word.
    localparam int NUM_EXC = 5;

    // Default layout of the status word.
    localparam int DEF_STAT_W  = 32;
    localparam int DEF_ENA_LSB = 0;
    localparam int DEF_FLG_LSB = 27;

    // Position of each class inside the enable field (and flag field).
    typedef enum logic [2:0] {
        CLS_INEXACT   = 3'd0,
        CLS_UNDERFLOW = 3'd1,
        CLS_OVERFLOW  = 3'd2,
        CLS_DIVZERO   = 3'd3,
        CLS_INVALID   = 3'd4
    } exc_cls_e;

    // Raw indications as presented by the arithmetic pipeline.
    typedef struct packed {
        logic inexact;
        logic underflow;
        logic overflow;
        logic divzero;
        logic invalid;
    } raw_exc_t;

    // Field-ordered exception vector (bit index = exc_cls_e value).
    typedef logic [NUM_EXC-1:0] exc_vec_t;

    // For a field position, the bit of the raw vector that feeds it.
    function automatic int raw_src_bit(input int field_pos);
        case (field_pos)
            int'(CLS_INEXACT):   return 4;
            int'(CLS_UNDERFLOW): return 3;
            int'(CLS_OVERFLOW):  return 2;
            int'(CLS_DIVZERO):   return 1;
            default:             return 0;
        endcase
    endfunction

endpackage

// File: rtl/fpx_exc_order.sv
module fpx_exc_order
    import fpx_pkg::*;
(
    input  logic [NUM_EXC-1:0] raw_in,
    output exc_vec_t           ord_out
);

    // Route each raw indication to its enable-field position.
    for (genvar g = 0; g < NUM_EXC; g++) begin : g_route
        localparam int SRC = raw_src_bit(g);
        assign ord_out[g] = raw_in[SRC];
    end

endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
    import fpx_pkg::*;
#(
    parameter int STAT_W  = DEF_STAT_W,
    parameter int ENA_LSB = DEF_ENA_LSB,
    parameter int FLG_LSB = DEF_FLG_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_we,
    input  logic [STAT_W-1:0] sw_wdata,
    input  logic              op_take,
    input  exc_vec_t          raised,
    output logic [STAT_W-1:0] word_q
);

    localparam int FLG_DIST = FLG_LSB - ENA_LSB;
    localparam int PAD_W    = STAT_W - NUM_EXC;

    logic [STAT_W-1:0] ena_aligned;
    logic [STAT_W-1:0] flg_place;
    logic [STAT_W-1:0] word_d;

    // Raised classes aligned to the enable field, then moved up to the flags.
    always_comb begin
        ena_aligned = {{PAD_W{1'b0}}, raised} << ENA_LSB;
        flg_place   = ena_aligned << FLG_DIST;
    end

    always_comb begin
        word_d = word_q;
        if (sw_we) begin
            word_d = sw_wdata;
        end else if (op_take) begin
            word_d = word_q | flg_place;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

endmodule

// File: rtl/fpx_trap_gen.sv
module fpx_trap_gen
    import fpx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     op_take,
    input  exc_vec_t raised,
    input  exc_vec_t enables,
    output logic     trap_q
);

    logic hit;

    always_comb begin
        hit = op_take && ((raised & enables) != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q <= 1'b0;
        end else begin
            trap_q <= hit;
        end
    end

endmodule

// File: rtl/fpx_flag_accum.sv
module fpx_flag_accum
    import fpx_pkg::*;
#(
    parameter int STAT_W  = DEF_STAT_W,
    parameter int ENA_LSB = DEF_ENA_LSB,
    parameter int FLG_LSB = DEF_FLG_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_done,
    input  logic [4:0]        op_exc,
    input  logic              sw_we,
    input  logic [STAT_W-1:0] sw_wdata,
    output logic [STAT_W-1:0] status,
    output logic              trap_req
);

    exc_vec_t raised;
    exc_vec_t enables;
    logic     op_take;

    // A software load discards an operation completing in the same cycle.
    assign op_take = op_done && !sw_we;
    assign enables = status[ENA_LSB +: NUM_EXC];

    fpx_exc_order u_order (
        .raw_in  (op_exc),
        .ord_out (raised)
    );

    fpx_status_reg #(
        .STAT_W  (STAT_W),
        .ENA_LSB (ENA_LSB),
        .FLG_LSB (FLG_LSB)
    ) u_word (
        .clk      (clk),
        .rst      (rst),
        .sw_we    (sw_we),
        .sw_wdata (sw_wdata),
        .op_take  (op_take),
        .raised   (raised),
        .word_q   (status)
    );

    fpx_trap_gen u_trap (
        .clk     (clk),
        .rst     (rst),
        .op_take (op_take),
        .raised  (raised),
        .enables (enables),
        .trap_q  (trap_req)
    );

endmodule

// File: rtl/fpx_flag_accum_chk.sv
module fpx_flag_accum_chk #(
    parameter int STAT_W  = 32,
    parameter int FLG_LSB = 27
) (
    input logic              clk,
    input logic              rst,
    input logic              op_done,
    input logic [4:0]        op_exc,
    input logic              sw_we,
    input logic [STAT_W-1:0] sw_wdata,
    input logic [STAT_W-1:0] status,
    input logic              trap_req
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (status == '0) && !trap_req);

    // R3
    flags_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !sw_we |=> ((status[STAT_W-1:FLG_LSB] & $past(status[STAT_W-1:FLG_LSB]))
                    == $past(status[STAT_W-1:FLG_LSB])));

    // R4
    clean_op_chk: assert property (@(posedge clk) disable iff (rst)
        (op_done && op_exc == 5'd0 && !sw_we) |=> $stable(status) && !trap_req);

    // R7
    sw_load_chk: assert property (@(posedge clk) disable iff (rst)
        sw_we |=> (status == $past(sw_wdata)) && !trap_req);

    // R8
    idle_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!op_done && !sw_we) |=> $stable(status) && !trap_req);

    // R10
    low_bits_kept_chk: assert property (@(posedge clk) disable iff (rst)
        !sw_we |=> status[FLG_LSB-1:0] == $past(status[FLG_LSB-1:0]));

    // R5
    trap_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> !trap_req || $past(op_done));

endmodule

bind fpx_flag_accum fpx_flag_accum_chk #(
    .STAT_W  (STAT_W),
    .FLG_LSB (FLG_LSB)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_done  (op_done),
    .op_exc   (op_exc),
    .sw_we    (sw_we),
    .sw_wdata (sw_wdata),
    .status   (status),
    .trap_req (trap_req)
);

// File: tb/tb_fpx_flag_accum.sv
module tb_fpx_flag_accum;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_done;
    logic [4:0]  op_exc;
    logic        sw_we;
    logic [31:0] sw_wdata;
    logic [31:0] status;
    logic        trap_req;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fpx_flag_accum dut (
        .clk      (clk),
        .rst      (rst),
        .op_done  (op_done),
        .op_exc   (op_exc),
        .sw_we    (sw_we),
        .sw_wdata (sw_wdata),
        .status   (status),
        .trap_req (trap_req)
    );

    // R2 field order: raw bit4 I,3 U,2 O,1 Z,0 V -> field bit0 I,1 U,2 O,3 Z,4 V
    function automatic logic [4:0] to_field(input logic [4:0] raw);
        logic [4:0] f;
        f[0] = raw[4];
        f[1] = raw[3];
        f[2] = raw[2];
        f[3] = raw[1];
        f[4] = raw[0];
        return f;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; spans one rising edge.
    task automatic cycle();
        @(negedge clk);
    endtask

    task automatic sw_load(input logic [31:0] w);
        sw_we = 1'b1; sw_wdata = w;
        cycle();
        sw_we = 1'b0; sw_wdata = '0;
    endtask

    task automatic do_op(input logic [4:0] raw);
        op_done = 1'b1; op_exc = raw;
        cycle();
        op_done = 1'b0; op_exc = 5'h1f; // garbage while idle (R8)
    endtask

    initial begin
        logic [31:0] base, exp_w;
        logic        exp_t;
        rst = 1'b1; op_done = 0; op_exc = 0; sw_we = 0; sw_wdata = 0;
        @(negedge clk);
        cycle(); cycle();
        check("R1 status", status, 32'h0);
        check("R1 trap", {31'b0, trap_req}, 32'h0);
        rst = 1'b0;
        cycle();

        // Near-exhaustive sweep: every enable pattern x every raw pattern.
        for (int en = 0; en < 32; en++) begin
            for (int raw = 0; raw < 32; raw++) begin
                base = {5'((en * 7 + raw * 3) & 5'h1a), 22'h2a5c3, 5'(en)};
                sw_load(base);
                do_op(5'(raw));
                exp_w = base | ({27'b0, to_field(5'(raw))} << 27);
                exp_t = |(to_field(5'(raw)) & 5'(en));
                check("R2/R3/R10 flags", status, exp_w);
                check(exp_t ? "R5 trap" : "R6 no trap", {31'b0, trap_req}, {31'b0, exp_t});
                cycle();
                check("R5 pulse width / R8 idle", {31'b0, trap_req}, 32'h0);
                check("R8 idle status", status, exp_w);
            end
        end

        // R4: clean op, enables all set
        sw_load(32'h0000_001f);
        do_op(5'd0);
        check("R4 status", status, 32'h0000_001f);
        check("R4 trap", {31'b0, trap_req}, 32'h0);

        // R3: accumulate across two ops, enables clear
        sw_load(32'h0);
        do_op(5'b10000);            // inexact -> bit27
        do_op(5'b00001);            // invalid -> bit31
        check("R3 accumulate", status, 32'h8800_0000);
        do_op(5'b00000);
        check("R3 kept", status, 32'h8800_0000);

        // R9: re-raise of already-set flag still traps
        sw_load(32'h4000_0008);     // divzero flag and enable set
        do_op(5'b00010);
        check("R9 status", status, 32'h4000_0008);
        check("R9 trap", {31'b0, trap_req}, 32'h1);

        // R7: load and op collide; load wins, no trap
        sw_load(32'h0000_001f);
        sw_we = 1'b1; sw_wdata = 32'h0000_001f;
        op_done = 1'b1; op_exc = 5'h1f;
        cycle();
        sw_we = 0; op_done = 0; op_exc = 0;
        check("R7 collision status", status, 32'h0000_001f);
        check("R7 collision trap", {31'b0, trap_req}, 32'h0);

        // R5: back-to-back trapping ops then silence
        do_op(5'b00100);
        check("R5 first", {31'b0, trap_req}, 32'h1);
        do_op(5'b01000);
        check("R5 second", {31'b0, trap_req}, 32'h1);
        cycle();
        check("R5 fall", {31'b0, trap_req}, 32'h0);
        check("R5 status", status, 32'h3000_001f);

        // R1: reset mid-run
        rst = 1'b1;
        cycle();
        rst = 1'b0;
        check("R1 rerun status", status, 32'h0);
        check("R1 rerun trap", {31'b0, trap_req}, 32'h0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule